// File: doc/BRIEF.md
# Three-Port Wormhole Tree Switch

This block is one router node of a binary-tree on-chip network. It has three ports, one toward the parent node and one toward each child. Each port has an input channel and an output channel that work independently, so flits can cross a link in both directions at the same time. Every channel moves one 32-bit flit per valid/acknowledge handshake.

Each input holds at most one flit. When a header flit reaches the front of an input, the switch decodes its destination against the address ranges configured for the left and right subtrees. It then claims the chosen output for the whole packet. Body flits follow the header along the claimed path, one at a time. The claim is dropped when the number of flits given in the header's length field have left. Other packets that want the same output wait until then. When two headers ask for a free output in the same cycle, a fixed per-output tie-break picks the winner. A weighted arbiter is a separate block and is not part of this one.

Top module: `tsw_switch`

## Requirements
- R1: While reset is asserted and right after it, no output channel is valid and every input buffer is empty. An input therefore acknowledges its first offered flit.
- R2: A flit is a header when bit 31 is 1 and a data flit when bit 31 is 0. In a header, bits 30:23 are the destination, bits 22:15 the source and bits 14:8 the packet length, counted in flits and including the header. A length of 0 is treated as 1.
- R3: A header entering on the parent port goes to the left output when its destination is in the left range [LEFT_LO, LEFT_HI]. Any other destination goes to the right output.
- R4: A header entering on a child port goes to the other child when its destination is in that child's range, and to the parent otherwise. No flit ever leaves on the port it came in on.
- R5: An input acknowledges only when its valid is high and its one-flit buffer is empty. After it accepts a flit, it acknowledges nothing more until that flit has left the buffer.
- R6: An output that raises valid keeps valid high and the flit unchanged until the downstream side acknowledges it.
- R7: A header reserves its output. The packet's flits then leave on that output in arrival order, with no flit of another packet between them.
- R8: The reservation ends when the output hands over the packet's last flit, as counted from the length field. A header waiting for that output takes it afterwards.
- R9: When both contenders for a free output present headers in the same cycle, the lower-numbered input wins unless the output's PICK_HI bit is set. Port numbering is parent 0, left 1, right 2.
- R10: A data flit that reaches the front of an input while no packet is in progress there is discarded without appearing on any output.
- R11: Packets that cross a port in opposite directions both make progress at the same time and both arrive complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 3 | Per-port inbound flit valid (bit 0 parent, 1 left, 2 right) |
| in_flit | input | 3*FLIT_W | Per-port inbound flit, port p at bits p*FLIT_W upward |
| in_ack | output | 3 | Per-port inbound acknowledge |
| out_vld | output | 3 | Per-port outbound flit valid |
| out_flit | output | 3*FLIT_W | Per-port outbound flit |
| out_ack | input | 3 | Per-port outbound acknowledge from the neighbour |

## Verification
The bench goes after the cases where a reservation can go wrong:
- A second packet's header arrives while a first packet is stalled halfway. A switch that released too early would interleave the two packets on the shared output.
- Two headers contend in the same cycle. A wrong tie-break changes which packet leaves first.
- A zero-length header and a stray data flit on an idle input. A switch that mishandled either would send the next header down the old path, or leak the stray flit to an output.
- A downstream stall. A switch that did not hold its flit would change or drop the flit and accept a second flit into a full buffer.
- Headers addressed back toward their own side. A switch that allowed U-turns would send them back out of their arrival port.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  // Port numbering used by every instance of the switch.
  typedef enum logic [1:0] {
    PORT_P = 2'd0,
    PORT_L = 2'd1,
    PORT_R = 2'd2
  } port_e;

  localparam int NPORT = 3;

  // One-hot request vector for a target port.
  function automatic logic [NPORT-1:0] port_bit(port_e p);
    return 3'b001 << p;
  endfunction

  // The two inputs allowed to feed an output (never the output's own port).
  function automatic int cand_a(int o);
    return (o == 0) ? 1 : 0;
  endfunction

  function automatic int cand_b(int o);
    return (o == 2) ? 1 : 2;
  endfunction

endpackage

// File: rtl/tsw_inbuf.sv
module tsw_inbuf import tsw_pkg::*; #(
  parameter int               FLIT_W   = 32,
  parameter int               ADDR_W   = 8,
  parameter int               LEN_W    = 7,
  parameter int               HDR_BIT  = 31,
  parameter int               DST_LSB  = 23,
  parameter int               LEN_LSB  = 8,
  parameter port_e            MY_PORT  = PORT_P,
  parameter logic [ADDR_W-1:0] LEFT_LO  = 8'h10,
  parameter logic [ADDR_W-1:0] LEFT_HI  = 8'h1F,
  parameter logic [ADDR_W-1:0] RIGHT_LO = 8'h20,
  parameter logic [ADDR_W-1:0] RIGHT_HI = 8'h2F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [FLIT_W-1:0] in_flit,
  output logic              in_ack,
  input  logic              grant,
  input  logic              pop,
  output logic              buf_full,
  output logic [FLIT_W-1:0] buf_flit,
  output logic [NPORT-1:0]  req_vec,
  output logic              last
);

  logic              full_q, full_d;
  logic              active_q, active_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [FLIT_W-1:0] flit_q;

  logic              push, drop, is_hdr, hit_l, hit_r;
  logic [ADDR_W-1:0] dst;
  logic [LEN_W-1:0]  len_f, len_eff;
  port_e             tgt;

  // Accept only into an empty slot; the flit leaves on pop or drop.
  assign push   = in_vld & ~full_q;
  assign in_ack = push;

  assign is_hdr  = flit_q[HDR_BIT];
  assign dst     = flit_q[DST_LSB +: ADDR_W];
  assign len_f   = flit_q[LEN_LSB +: LEN_W];
  assign len_eff = (len_f == '0) ? LEN_W'(1) : len_f;

  assign hit_l = (dst >= LEFT_LO)  && (dst <= LEFT_HI);
  assign hit_r = (dst >= RIGHT_LO) && (dst <= RIGHT_HI);

  // Tree routing: never send a flit back out of its arrival port.
  always_comb begin
    case (MY_PORT)
      PORT_P:  tgt = hit_l ? PORT_L : PORT_R;
      PORT_L:  tgt = hit_r ? PORT_R : PORT_P;
      default: tgt = hit_l ? PORT_L : PORT_P;
    endcase
  end

  // A body flit without an open packet has nowhere to go.
  assign drop    = full_q & ~active_q & ~is_hdr;
  assign req_vec = (full_q & ~active_q & is_hdr) ? port_bit(tgt) : '0;
  assign last    = (rem_q == LEN_W'(1));

  assign buf_full = full_q;
  assign buf_flit = flit_q;

  always_comb begin
    full_d   = full_q;
    active_d = active_q;
    rem_d    = rem_q;
    if (push)
      full_d = 1'b1;
    else if (pop || drop)
      full_d = 1'b0;
    if (grant) begin
      active_d = 1'b1;
      rem_d    = len_eff;
    end else if (pop) begin
      rem_d = rem_q - LEN_W'(1);
      if (last)
        active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q   <= 1'b0;
      active_q <= 1'b0;
      rem_q    <= '0;
    end else begin
      full_q   <= full_d;
      active_q <= active_d;
      rem_q    <= rem_d;
    end
  end

  // Data storage: clock enable only, no reset.
  always_ff @(posedge clk) begin
    if (push)
      flit_q <= in_flit;
  end

endmodule

// File: rtl/tsw_outport.sv
module tsw_outport #(
  parameter int FLIT_W  = 32,
  parameter bit PICK_HI = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_a,
  input  logic              req_b,
  input  logic              full_a,
  input  logic              full_b,
  input  logic              last_a,
  input  logic              last_b,
  input  logic [FLIT_W-1:0] flit_a,
  input  logic [FLIT_W-1:0] flit_b,
  input  logic              out_ack,
  output logic              out_vld,
  output logic [FLIT_W-1:0] out_flit,
  output logic              gnt_a,
  output logic              gnt_b,
  output logic              pop_a,
  output logic              pop_b
);

  logic busy_q, busy_d;
  logic own_b_q, own_b_d;
  logic xfer, own_last;

  // Reservation is only handed out while the output is free.
  always_comb begin
    gnt_a = 1'b0;
    gnt_b = 1'b0;
    if (!busy_q) begin
      if (req_a && req_b) begin
        gnt_a = ~PICK_HI;
        gnt_b = PICK_HI;
      end else begin
        gnt_a = req_a;
        gnt_b = req_b;
      end
    end
  end

  assign out_vld  = busy_q & (own_b_q ? full_b : full_a);
  assign out_flit = own_b_q ? flit_b : flit_a;
  assign xfer     = out_vld & out_ack;
  assign pop_a    = xfer & ~own_b_q;
  assign pop_b    = xfer & own_b_q;
  assign own_last = own_b_q ? last_b : last_a;

  always_comb begin
    busy_d  = busy_q;
    own_b_d = own_b_q;
    if (gnt_a || gnt_b) begin
      busy_d  = 1'b1;
      own_b_d = gnt_b;
    end else if (xfer && own_last) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      own_b_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      own_b_q <= own_b_d;
    end
  end

endmodule

// File: rtl/tsw_switch.sv
module tsw_switch import tsw_pkg::*; #(
  parameter int                FLIT_W   = 32,
  parameter int                ADDR_W   = 8,
  parameter int                LEN_W    = 7,
  parameter logic [ADDR_W-1:0] LEFT_LO  = 8'h10,
  parameter logic [ADDR_W-1:0] LEFT_HI  = 8'h1F,
  parameter logic [ADDR_W-1:0] RIGHT_LO = 8'h20,
  parameter logic [ADDR_W-1:0] RIGHT_HI = 8'h2F,
  parameter logic [2:0]        PICK_HI  = 3'b000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          in_vld,
  input  logic [3*FLIT_W-1:0] in_flit,
  output logic [2:0]          in_ack,
  output logic [2:0]          out_vld,
  output logic [3*FLIT_W-1:0] out_flit,
  input  logic [2:0]          out_ack
);

  // Header field positions, packed from the top bit downward.
  localparam int HDR_BIT = FLIT_W - 1;
  localparam int DST_LSB = HDR_BIT - ADDR_W;
  localparam int SRC_LSB = DST_LSB - ADDR_W;
  localparam int LEN_LSB = SRC_LSB - LEN_W;

  logic [NPORT-1:0]  req_v    [NPORT];
  logic [FLIT_W-1:0] buf_flit [NPORT];
  logic              full_v   [NPORT];
  logic              last_v   [NPORT];
  logic              grant_in [NPORT];
  logic              pop_in   [NPORT];
  logic              gnt_a    [NPORT];
  logic              gnt_b    [NPORT];
  logic              pop_a    [NPORT];
  logic              pop_b    [NPORT];

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    tsw_inbuf #(
      .FLIT_W  (FLIT_W),
      .ADDR_W  (ADDR_W),
      .LEN_W   (LEN_W),
      .HDR_BIT (HDR_BIT),
      .DST_LSB (DST_LSB),
      .LEN_LSB (LEN_LSB),
      .MY_PORT (port_e'(i)),
      .LEFT_LO (LEFT_LO),
      .LEFT_HI (LEFT_HI),
      .RIGHT_LO(RIGHT_LO),
      .RIGHT_HI(RIGHT_HI)
    ) u_inbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (in_vld[i]),
      .in_flit (in_flit[i*FLIT_W +: FLIT_W]),
      .in_ack  (in_ack[i]),
      .grant   (grant_in[i]),
      .pop     (pop_in[i]),
      .buf_full(full_v[i]),
      .buf_flit(buf_flit[i]),
      .req_vec (req_v[i]),
      .last    (last_v[i])
    );
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    localparam int CA = cand_a(o);
    localparam int CB = cand_b(o);
    tsw_outport #(
      .FLIT_W (FLIT_W),
      .PICK_HI(PICK_HI[o])
    ) u_outport (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_a   (req_v[CA][o]),
      .req_b   (req_v[CB][o]),
      .full_a  (full_v[CA]),
      .full_b  (full_v[CB]),
      .last_a  (last_v[CA]),
      .last_b  (last_v[CB]),
      .flit_a  (buf_flit[CA]),
      .flit_b  (buf_flit[CB]),
      .out_ack (out_ack[o]),
      .out_vld (out_vld[o]),
      .out_flit(out_flit[o*FLIT_W +: FLIT_W]),
      .gnt_a   (gnt_a[o]),
      .gnt_b   (gnt_b[o]),
      .pop_a   (pop_a[o]),
      .pop_b   (pop_b[o])
    );
  end

  // Fold per-output grants and pops back onto the inputs they serve.
  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      grant_in[i] = 1'b0;
      pop_in[i]   = 1'b0;
      for (int o = 0; o < NPORT; o++) begin
        if (cand_a(o) == i) begin
          grant_in[i] = grant_in[i] | gnt_a[o];
          pop_in[i]   = pop_in[i]   | pop_a[o];
        end
        if (cand_b(o) == i) begin
          grant_in[i] = grant_in[i] | gnt_b[o];
          pop_in[i]   = pop_in[i]   | pop_b[o];
        end
      end
    end
  end

endmodule

// File: rtl/tsw_checker.sv
module tsw_checker #(
  parameter int FLIT_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          in_vld,
  input logic [2:0]          in_ack,
  input logic [2:0]          out_vld,
  input logic [3*FLIT_W-1:0] out_flit,
  input logic [2:0]          out_ack
);

  always @(posedge clk) begin
    if (!rst_n) begin
      // R1
      reset_quiet_chk: assert (out_vld == 3'b000);
    end
  end

  for (genvar p = 0; p < 3; p++) begin : g_port
    // R6
    hold_flit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[p] && !out_ack[p] |=> out_vld[p] && $stable(out_flit[p*FLIT_W +: FLIT_W]));

    // R5
    ack_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ack[p] |-> in_vld[p]);

    // R5
    single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ack[p] |=> !in_ack[p]);
  end

endmodule

bind tsw_switch tsw_checker #(.FLIT_W(FLIT_W)) u_tsw_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_vld  (in_vld),
  .in_ack  (in_ack),
  .out_vld (out_vld),
  .out_flit(out_flit),
  .out_ack (out_ack)
);

// File: tb/tsw_switch_test.sv
module tsw_switch_test;

  localparam int T  = 10;
  localparam int PP = 0;
  localparam int PL = 1;
  localparam int PR = 2;

  logic        clk;
  logic        rst_n;
  logic [2:0]  in_vld;
  logic [95:0] in_flit;
  logic [2:0]  in_ack;
  logic [2:0]  out_vld;
  logic [95:0] out_flit;
  logic [2:0]  out_ack;

  int total;
  int bad;
  logic [31:0] cap [3][32];
  int          cap_n [3];

  tsw_switch uut (
    .clk(clk), .rst_n(rst_n),
    .in_vld(in_vld), .in_flit(in_flit), .in_ack(in_ack),
    .out_vld(out_vld), .out_flit(out_flit), .out_ack(out_ack)
  );

  initial clk = 1'b0;
  always #(T/2) clk = ~clk;

  // Record every accepted outbound flit, sampled just before the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #(T/2 - 1);
      for (int p = 0; p < 3; p++) begin
        if (rst_n && out_vld[p] && out_ack[p]) begin
          if (cap_n[p] < 32) cap[p][cap_n[p]] = out_flit[p*32 +: 32];
          cap_n[p]++;
        end
      end
    end
  end

  function automatic logic [31:0] hdr(logic [7:0] d, logic [7:0] s, logic [6:0] n);
    return {1'b1, d, s, n, 8'h00};
  endfunction

  function automatic logic [31:0] dat(int tag);
    return {1'b0, 31'(tag)};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_cap();
    for (int p = 0; p < 3; p++) cap_n[p] = 0;
  endtask

  task automatic send_flit(int p, logic [31:0] f);
    @(negedge clk);
    in_vld[p] = 1'b1;
    in_flit[p*32 +: 32] = f;
    for (int k = 0; k < 2000; k++) begin
      #2;
      if (in_ack[p]) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    in_vld[p] = 1'b0;
  endtask

  task automatic send_pkt(int p, logic [7:0] d, logic [6:0] n, int nfl);
    send_flit(p, hdr(d, 8'(p), n));
    for (int k = 1; k < nfl; k++) send_flit(p, dat(p*256 + k));
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic t_reset();
    settle(2);
    chk(out_vld == 3'b000, "R1 out_vld", 32'(out_vld), 0);
    chk(in_ack == 3'b000, "R1 in_ack", 32'(in_ack), 0);
  endtask

  task automatic t_parent_route();
    clear_cap();
    send_pkt(PP, 8'h12, 7'd2, 2);
    send_pkt(PP, 8'h50, 7'd1, 1);
    settle(10);
    chk(cap_n[PL] == 2, "R3 left count", 32'(cap_n[PL]), 2);
    chk(cap[PL][0] == hdr(8'h12, 8'h00, 7'd2), "R3 left hdr", cap[PL][0], hdr(8'h12, 8'h00, 7'd2));
    chk(cap[PL][1] == dat(1), "R3 left body", cap[PL][1], dat(1));
    chk(cap_n[PR] == 1, "R3 other dest goes right", 32'(cap_n[PR]), 1);
    chk(cap_n[PP] == 0, "R4 no u-turn at parent", 32'(cap_n[PP]), 0);
  endtask

  task automatic t_child_route();
    clear_cap();
    send_pkt(PL, 8'h25, 7'd3, 3);
    send_pkt(PL, 8'h15, 7'd1, 1);
    send_pkt(PR, 8'h11, 7'd1, 1);
    send_pkt(PR, 8'h77, 7'd1, 1);
    settle(10);
    chk(cap_n[PR] == 3, "R4 left to right count", 32'(cap_n[PR]), 3);
    chk(cap[PR][2] == dat(258), "R4 last body", cap[PR][2], dat(258));
    chk(cap_n[PL] == 1, "R4 right to left count", 32'(cap_n[PL]), 1);
    chk(cap_n[PP] == 2, "R4 up count", 32'(cap_n[PP]), 2);
    chk(cap[PP][0] == hdr(8'h15, 8'h01, 7'd1), "R4 own range goes up", cap[PP][0], hdr(8'h15, 8'h01, 7'd1));
    chk(cap[PP][1] == hdr(8'h77, 8'h02, 7'd1), "R4 unknown goes up", cap[PP][1], hdr(8'h77, 8'h02, 7'd1));
  endtask

  task automatic t_hold();
    clear_cap();
    @(negedge clk);
    out_ack[PP] = 1'b0;
    send_pkt(PL, 8'h50, 7'd1, 1);
    settle(5);
    chk(out_vld[PP] == 1'b1, "R6 valid raised", 32'(out_vld[PP]), 1);
    chk(out_flit[PP*32 +: 32] == hdr(8'h50, 8'h01, 7'd1), "R6 flit", out_flit[PP*32 +: 32], hdr(8'h50, 8'h01, 7'd1));
    in_vld[PL] = 1'b1;
    in_flit[PL*32 +: 32] = dat(12'hABC);
    settle(4);
    chk(in_ack[PL] == 1'b0, "R5 full buffer no ack", 32'(in_ack[PL]), 0);
    chk(out_vld[PP] && out_flit[PP*32 +: 32] == hdr(8'h50, 8'h01, 7'd1), "R6 held under stall",
        out_flit[PP*32 +: 32], hdr(8'h50, 8'h01, 7'd1));
    in_vld[PL] = 1'b0;
    out_ack[PP] = 1'b1;
    settle(4);
    chk(cap_n[PP] == 1, "R6 delivered once", 32'(cap_n[PP]), 1);
    send_flit(PL, dat(12'hABC));
    settle(6);
    chk(cap_n[PP] == 1 && cap_n[PL] == 0 && cap_n[PR] == 0, "R10 stray discarded",
        32'(cap_n[PP] + cap_n[PL] + cap_n[PR]), 1);
    send_pkt(PL, 8'h50, 7'd1, 1);
    settle(6);
    chk(cap_n[PP] == 2 && cap[PP][1] == hdr(8'h50, 8'h01, 7'd1), "R10 next header routed",
        cap[PP][1], hdr(8'h50, 8'h01, 7'd1));
  endtask

  task automatic t_reserve();
    clear_cap();
    fork
      begin
        send_flit(PL, hdr(8'h50, 8'h01, 7'd3));
        send_flit(PL, dat(32'h101));
        settle(8);
        send_flit(PL, dat(32'h102));
      end
      begin
        settle(3);
        send_pkt(PR, 8'h50, 7'd2, 2);
      end
    join
    settle(10);
    chk(cap_n[PP] == 5, "R7 count", 32'(cap_n[PP]), 5);
    chk(cap[PP][2] == dat(32'h102), "R7 no interleave", cap[PP][2], dat(32'h102));
    chk(cap[PP][3] == hdr(8'h50, 8'h02, 7'd2), "R8 waiter after release", cap[PP][3], hdr(8'h50, 8'h02, 7'd2));
  endtask

  task automatic t_contend();
    clear_cap();
    fork
      send_pkt(PL, 8'h50, 7'd2, 2);
      send_pkt(PR, 8'h50, 7'd2, 2);
    join
    settle(10);
    chk(cap[PP][0] == hdr(8'h50, 8'h01, 7'd2), "R9 lower index first", cap[PP][0], hdr(8'h50, 8'h01, 7'd2));
    chk(cap[PP][2] == hdr(8'h50, 8'h02, 7'd2), "R9 loser follows", cap[PP][2], hdr(8'h50, 8'h02, 7'd2));
  endtask

  task automatic t_len0();
    clear_cap();
    send_flit(PR, hdr(8'h12, 8'h02, 7'd0));
    send_flit(PR, hdr(8'h77, 8'h02, 7'd1));
    settle(8);
    chk(cap_n[PL] == 1, "R2 zero length is one flit", 32'(cap_n[PL]), 1);
    chk(cap_n[PP] == 1, "R2 next header reroutes", 32'(cap_n[PP]), 1);
  endtask

  task automatic t_bidir();
    clear_cap();
    fork
      send_pkt(PL, 8'h50, 7'd3, 3);
      send_pkt(PP, 8'h12, 7'd3, 3);
    join
    settle(8);
    chk(cap_n[PP] == 3, "R11 upward complete", 32'(cap_n[PP]), 3);
    chk(cap_n[PL] == 3, "R11 downward complete", 32'(cap_n[PL]), 3);
  endtask

  initial begin
    #(T * 100000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    total = 0;
    bad = 0;
    clear_cap();
    in_vld = 3'b000;
    in_flit = '0;
    out_ack = 3'b111;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    settle(3);
    t_reset();
    rst_n = 1'b1;
    settle(2);
    t_parent_route();
    t_child_route();
    t_hold();
    t_reserve();
    t_contend();
    t_len0();
    t_bidir();
    finish_run();
  end

endmodule